// File: doc/BRIEF.md
# CSMA/CD Transmit Frame Sequencer

This block sends one frame at a time onto a shared 10 Mb/s medium, one bit per clock cycle. Each clock cycle is one bit time. Frame bytes come from a transmit FIFO through a valid/ready stream that carries 8 data bits and a last-byte flag. The block waits until the line has been quiet for the inter-frame gap and the external backoff logic no longer holds it off. It then sends the preamble and start delimiter, the FIFO bytes and, unless suppressed for that frame, a CRC-32 trailer. It drives the transmit enable line for the whole frame.

If a collision is reported while the frame is on the line, the block drops the FIFO data and sends a fixed jam pattern. It then asks the buffer manager to reload the frame and tells the backoff logic to start its wait. If the FIFO has no byte ready when one is needed, the block ends the attempt at once and reports an underflow. Every attempt ends with a one-cycle done pulse and a fresh status that names the outcome.

On the stream, the block pulls only one byte per 8 bit times, and only at the last bit of the byte in flight. It raises `fifo_ready` for that single cycle. A byte moves on a rising edge where `fifo_valid` and `fifo_ready` are both high. The FIFO must hold its byte stable while valid and not accepted, and must not withdraw it. The block applies back-pressure for the rest of the time. Valid low in a ready cycle is not a stall: it is an underflow.

Top module: `csma_tx_sequencer`

## Requirements
- R1: A frame starts only after `carrier_sense` and `tx_en` have both been low for IFG_BITS (default 96) consecutive cycles. With a byte offered and no backoff hold, the first bit appears on `tx_en`/`tx_bit` after exactly IFG_BITS+1 rising edges counted from the cycle in which carrier drops.
- R2: While `backoff_busy` is high no frame starts. When it falls and the other start conditions hold, the frame starts on the next rising edge.
- R3: `tx_en` rises in the same cycle as the first preamble bit. It stays high through the last bit of the attempt and is low in the cycle that follows the last bit.
- R4: The bit order on `tx_bit` is seven bytes of 0x55, then the delimiter 0xD5, then the FIFO bytes in order. Every byte is sent least significant bit first.
- R5: Unless `no_crc` was high in the start cycle, the last data bit is followed by 32 CRC bits. The CRC uses the reflected polynomial 0xEDB88320 over the data bytes, starts at all ones, is inverted at the end and is sent least significant bit first. With `no_crc` set, the frame ends after the last data bit.
- R6: A byte is taken only on an edge where `fifo_valid` and `fifo_ready` are both high. `fifo_ready` is high for exactly one cycle per byte, in the last bit of the byte in flight. A byte taken with `fifo_last` high is the final data byte, and no further byte is requested.
- R7: A `collision` seen during preamble, data or CRC switches `tx_bit` on the next cycle to a 32-bit jam of 0x55 (bits 1,0,1,0,...). The jam has fixed length whatever `collision` does while it runs. `collision` has no effect while idle.
- R8: In the cycle after the jam ends, `retry_req`, `backoff_start` and `done` pulse for one cycle and the status shows collision only.
- R9: If `fifo_ready` is high and `fifo_valid` low, `tx_en` is low on the next cycle. In that cycle `retry_req` and `done` pulse and the status shows underflow only. `backoff_start` stays low.
- R10: A frame that ends without collision or underflow pulses `done` and shows `status_ok` only, with no `retry_req`. In every case exactly one status bit is set at `done`, and the status holds until the next `done`.
- R11: During and right after reset, `tx_en`, `tx_bit`, `fifo_ready`, `retry_req`, `backoff_start`, `done` and all status bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision reported on the medium |
| backoff_busy | input | 1 | Backoff wait still running; holds off a start |
| no_crc | input | 1 | Omit the CRC trailer; sampled at frame start |
| fifo_valid | input | 1 | FIFO offers a byte |
| fifo_ready | output | 1 | Block takes the offered byte this cycle |
| fifo_data | input | 8 | Offered byte |
| fifo_last | input | 1 | Offered byte is the last of the frame |
| tx_en | output | 1 | Transmit enable, high for the whole attempt |
| tx_bit | output | 1 | Serial transmit data |
| retry_req | output | 1 | One-cycle pulse: frame must be reloaded |
| backoff_start | output | 1 | One-cycle pulse: begin backoff wait |
| done | output | 1 | One-cycle pulse at the end of every attempt |
| status_ok | output | 1 | Last attempt completed |
| status_collision | output | 1 | Last attempt ended in jam |
| status_underflow | output | 1 | Last attempt ended for lack of data |

## Verification
The hardest case to reach is a collision that lands in the CRC trailer. From the ports, the data bits have long since been consumed by then, and the jam must still replace the trailer bit-exactly. The bench counts the bits it has captured since `tx_en` rose and raises `collision` for one cycle at a chosen bit index inside the trailer. It does the same at points in the preamble, and it holds collision high across the jam to show the jam length does not change. Underflow is produced by a FIFO model that offers fewer bytes than the frame length, so the starved request falls on a known byte boundary.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_CRC,
    ST_JAM
  } seq_state_e;

  localparam logic [7:0]  PRE_PATTERN = 8'h55;
  localparam logic [7:0]  SFD_PATTERN = 8'hD5;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam int          CRC_BITS    = 32;
endpackage

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int IFG_BITS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_busy,
  output logic gap_met
);
  localparam int CW = $clog2(IFG_BITS + 1);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          quiet_cnt <= '0;
    else if (line_busy)                  quiet_cnt <= '0;
    else if (quiet_cnt != CW'(IFG_BITS)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign gap_met = (quiet_cnt == CW'(IFG_BITS));

  AST_GAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    line_busy |=> !gap_met); // R1
endmodule

// File: rtl/tx_crc32_lsb.sv
module tx_crc32_lsb
  import tx_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic update,
  input  logic din,
  input  logic shift,
  output logic out_bit
);
  logic [CRC_BITS-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= '1;
    else if (update)    crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? CRC_POLY : '0);
    else if (shift)     crc_q <= {1'b1, crc_q[CRC_BITS-1:1]};
  end

  assign out_bit = ~crc_q[0];

  AST_CRC_ONE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    !(update && shift)); // R5
endmodule

// File: rtl/tx_byte_shifter.sv
module tx_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  output logic         out_bit,
  output logic         at_last
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_val;
      idx_q <= '0;
    end else if (advance) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign out_bit = sh_q[0];
  assign at_last = (idx_q == IW'(W - 1));

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !at_last) |=> (out_bit == $past(sh_q[1]))); // R4
endmodule

// File: rtl/csma_tx_sequencer.sv
module csma_tx_sequencer
  import tx_seq_pkg::*;
#(
  parameter int IFG_BITS  = 96,
  parameter int PRE_BYTES = 7,
  parameter int JAM_BITS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_sense,
  input  logic       collision,
  input  logic       backoff_busy,
  input  logic       no_crc,
  input  logic       fifo_valid,
  output logic       fifo_ready,
  input  logic [7:0] fifo_data,
  input  logic       fifo_last,
  output logic       tx_en,
  output logic       tx_bit,
  output logic       retry_req,
  output logic       backoff_start,
  output logic       done,
  output logic       status_ok,
  output logic       status_collision,
  output logic       status_underflow
);
  localparam int PW       = $clog2(PRE_BYTES + 2);
  localparam int TAIL_MAX = (JAM_BITS > CRC_BITS) ? JAM_BITS : CRC_BITS;
  localparam int TW       = $clog2(TAIL_MAX);

  seq_state_e    state_q;
  logic [PW-1:0] pre_cnt_q;
  logic [TW-1:0] tail_q;
  logic          last_q, no_crc_q;

  logic gap_met, sh_bit, sh_last, crc_bit;
  logic start, sending, col_hit, need_byte, take, starve;
  logic data_tail, crc_end, jam_end, fin_ok, fin_col, fin_unf;
  logic sh_load, sh_adv;
  logic [7:0] sh_val;

  tx_defer_timer #(.IFG_BITS(IFG_BITS)) u_defer (
    .clk(clk), .rst_n(rst_n), .line_busy(carrier_sense | tx_en), .gap_met(gap_met)
  );

  assign start     = (state_q == ST_IDLE) && fifo_valid && gap_met && !backoff_busy;
  assign sending   = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_CRC);
  assign col_hit   = sending && collision;
  assign need_byte = !col_hit && sh_last &&
                     (((state_q == ST_PRE) && (pre_cnt_q == PW'(PRE_BYTES + 1))) ||
                      ((state_q == ST_DATA) && !last_q));
  assign fifo_ready = need_byte;
  assign take      = need_byte && fifo_valid;
  assign starve    = need_byte && !fifo_valid;
  assign data_tail = !col_hit && (state_q == ST_DATA) && sh_last && last_q;
  assign crc_end   = !col_hit && (state_q == ST_CRC) && (tail_q == TW'(CRC_BITS - 1));
  assign jam_end   = (state_q == ST_JAM) && (tail_q == TW'(JAM_BITS - 1));
  assign fin_ok    = (data_tail && no_crc_q) || crc_end;
  assign fin_col   = jam_end;
  assign fin_unf   = starve;

  assign sh_load = start || (!col_hit && sh_last && ((state_q == ST_PRE) || (state_q == ST_DATA)));
  assign sh_adv  = (state_q == ST_PRE) || (state_q == ST_DATA);

  always_comb begin
    if (start)                                                      sh_val = PRE_PATTERN;
    else if ((state_q == ST_DATA) || (pre_cnt_q == PW'(PRE_BYTES + 1))) sh_val = fifo_data;
    else if (pre_cnt_q < PW'(PRE_BYTES))                            sh_val = PRE_PATTERN;
    else                                                            sh_val = SFD_PATTERN;
  end

  tx_byte_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .advance(sh_adv), .out_bit(sh_bit), .at_last(sh_last)
  );

  tx_crc32_lsb u_crc (
    .clk(clk), .rst_n(rst_n), .init(start), .update(state_q == ST_DATA),
    .din(sh_bit), .shift(state_q == ST_CRC), .out_bit(crc_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pre_cnt_q <= '0;
      tail_q    <= '0;
      last_q    <= 1'b0;
      no_crc_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_PRE;
          pre_cnt_q <= PW'(1);
          no_crc_q  <= no_crc;
          last_q    <= 1'b0;
        end
        ST_PRE: begin
          if (col_hit) begin
            state_q <= ST_JAM;
            tail_q  <= '0;
          end else if (take) begin
            state_q <= ST_DATA;
            last_q  <= fifo_last;
          end else if (starve) begin
            state_q <= ST_IDLE;
          end else if (sh_last) begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (col_hit) begin
            state_q <= ST_JAM;
            tail_q  <= '0;
          end else if (take) begin
            last_q <= fifo_last;
          end else if (starve || (data_tail && no_crc_q)) begin
            state_q <= ST_IDLE;
          end else if (data_tail) begin
            state_q <= ST_CRC;
            tail_q  <= '0;
          end
        end
        ST_CRC: begin
          if (col_hit) begin
            state_q <= ST_JAM;
            tail_q  <= '0;
          end else if (crc_end) begin
            state_q <= ST_IDLE;
          end else begin
            tail_q <= tail_q + 1'b1;
          end
        end
        ST_JAM: begin
          if (jam_end) state_q <= ST_IDLE;
          else         tail_q  <= tail_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done             <= 1'b0;
      retry_req        <= 1'b0;
      backoff_start    <= 1'b0;
      status_ok        <= 1'b0;
      status_collision <= 1'b0;
      status_underflow <= 1'b0;
    end else begin
      done          <= fin_ok | fin_col | fin_unf;
      retry_req     <= fin_col | fin_unf;
      backoff_start <= fin_col;
      if (fin_ok | fin_col | fin_unf) begin
        status_ok        <= fin_ok;
        status_collision <= fin_col;
        status_underflow <= fin_unf;
      end
    end
  end

  assign tx_en = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_PRE, ST_DATA: tx_bit = sh_bit;
      ST_CRC:          tx_bit = crc_bit;
      ST_JAM:          tx_bit = ~tail_q[0];
      default:         tx_bit = 1'b0;
    endcase
  end

  AST_START_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(gap_met)); // R1
  AST_START_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(!backoff_busy)); // R2
  AST_DONE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_en); // R3
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && !fifo_valid) |=> (done && status_underflow)); // R9
  AST_BACKOFF_ON_COL: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_start |-> (retry_req && status_collision)); // R8
  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (done && !status_ok)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({status_ok, status_collision, status_underflow}) == 1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({status_ok, status_collision, status_underflow})); // R10
endmodule

// File: tb/test_csma_tx_sequencer.sv
module test_csma_tx_sequencer;
  localparam int IFG = 96;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, carrier_sense, collision, backoff_busy, no_crc;
  logic fifo_valid, fifo_ready, fifo_last;
  logic [7:0] fifo_data;
  logic tx_en, tx_bit, retry_req, backoff_start, done;
  logic status_ok, status_collision, status_underflow;

  logic [7:0] fmem [0:63];
  logic [5:0] fidx;
  int flen, favail;
  logic f_clear;

  assign fifo_valid = (int'(fidx) < favail) && (int'(fidx) < flen);
  assign fifo_data  = fmem[fidx];
  assign fifo_last  = (int'(fidx) == flen - 1);

  always @(posedge clk) begin
    if (f_clear) fidx <= '0;
    else if (fifo_valid && fifo_ready) fidx <= fidx + 1'b1;
  end

  csma_tx_sequencer i_csma_tx_sequencer (
    .clk(clk), .rst_n(rst_n), .carrier_sense(carrier_sense), .collision(collision),
    .backoff_busy(backoff_busy), .no_crc(no_crc), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .tx_en(tx_en), .tx_bit(tx_bit), .retry_req(retry_req), .backoff_start(backoff_start),
    .done(done), .status_ok(status_ok), .status_collision(status_collision),
    .status_underflow(status_underflow)
  );

  int checks = 0, errors = 0;
  logic cap [0:2047];
  logic expb [0:2047];
  int ncap, nexp;
  logic e_done, e_retry, e_bo, e_ok, e_col, e_unf, e_done_next;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fmem[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic build_exp(input int n, input bit with_crc);
    logic [31:0] c;
    nexp = 0;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 8; b++) begin
        expb[nexp] = (k == 7) ? 1'(8'hD5 >> b) : 1'(8'h55 >> b);
        nexp++;
      end
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        expb[nexp] = fmem[i][b];
        nexp++;
      end
    if (with_crc) begin
      c = crc_of(n);
      for (int b = 0; b < 32; b++) begin
        expb[nexp] = c[b];
        nexp++;
      end
    end
  endtask

  task automatic load_fifo(input int n, input int avail, input int seed);
    @(negedge clk);
    f_clear = 1'b1;
    favail = 0;
    @(negedge clk);
    f_clear = 1'b0;
    for (int i = 0; i < n; i++) fmem[i] = 8'((i * 37 + seed * 11 + 3) ^ (seed << 4));
    flen = n;
    favail = avail;
  endtask

  // col_at: raise collision after that many bits captured (0 = never), for col_len cycles
  task automatic capture(input int col_at, input int col_len);
    int guard = 0;
    ncap = 0;
    while (!tx_en && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    while (tx_en && ncap < 2048) begin
      cap[ncap] = tx_bit;
      ncap++;
      collision = (col_at > 0) && (ncap >= col_at) && (ncap < col_at + col_len);
      @(negedge clk);
    end
    collision = 1'b0;
    e_done = done; e_retry = retry_req; e_bo = backoff_start;
    e_ok = status_ok; e_col = status_collision; e_unf = status_underflow;
    @(negedge clk);
    e_done_next = done | retry_req | backoff_start;
  endtask

  task automatic cmp_bits(input string req, input int from, input int upto);
    int bad = 0, first = -1;
    for (int i = from; i < upto; i++)
      if (cap[i] !== expb[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, "bit mismatches (first index)", first, -1);
  endtask

  task automatic cmp_jam(input int from);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (cap[from + i] !== ((i % 2) == 0)) bad++;
    chk(bad == 0, "R7", "jam bit mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk({tx_en, tx_bit, fifo_ready, retry_req, backoff_start, done,
         status_ok, status_collision, status_underflow} == 9'b0,
        "R11", "outputs in reset", int'(tx_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_en, retry_req, done, status_ok, status_collision, status_underflow} == 6'b0,
        "R11", "outputs after reset", int'(done), 0);
  endtask

  task automatic t_defer_and_frame();
    int n = 0;
    carrier_sense = 1'b1;
    load_fifo(5, 5, 1);
    repeat (20) @(negedge clk);
    carrier_sense = 1'b0;
    while (!tx_en && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n == IFG + 1, "R1", "edges from carrier drop to first bit", n, IFG + 1);
    chk(tx_bit == 1'b1, "R3", "first bit with tx_en", int'(tx_bit), 1);
    capture(0, 0);
    build_exp(5, 1'b1);
    chk(ncap == nexp, "R3", "tx_en length with CRC", ncap, nexp);
    cmp_bits("R4", 0, 64 + 40);
    cmp_bits("R5", 64 + 40, nexp);
    chk(e_done && e_ok && !e_col && !e_unf && !e_retry && !e_bo, "R10", "success status",
        int'({e_done, e_ok, e_col, e_unf, e_retry}), 5'b11000);
    chk(!e_done_next, "R10", "done width", int'(e_done_next), 0);
    chk(int'(fidx) == 5, "R6", "bytes taken", int'(fidx), 5);
  endtask

  task automatic t_backoff_hold();
    int early = 0;
    backoff_busy = 1'b1;
    load_fifo(3, 3, 2);
    repeat (150) begin
      @(negedge clk);
      if (tx_en) early++;
    end
    chk(early == 0, "R2", "cycles sent under backoff hold", early, 0);
    backoff_busy = 1'b0;
    @(negedge clk);
    chk(tx_en == 1'b1, "R2", "start one edge after hold release", int'(tx_en), 1);
    no_crc = 1'b0;
    capture(0, 0);
    build_exp(3, 1'b1);
    chk(ncap == nexp, "R5", "length", ncap, nexp);
    cmp_bits("R5", 0, nexp);
  endtask

  task automatic t_no_crc();
    no_crc = 1'b1;
    load_fifo(4, 4, 3);
    capture(0, 0);
    no_crc = 1'b0;
    build_exp(4, 1'b0);
    chk(ncap == 64 + 32, "R5", "length without CRC", ncap, 64 + 32);
    cmp_bits("R4", 0, nexp);
    chk(e_done && e_ok, "R10", "no-CRC success", int'({e_done, e_ok}), 3);
    chk(int'(fidx) == 4, "R6", "last flag stops requests", int'(fidx), 4);
  endtask

  task automatic t_collision(input int at, input int len, input int nbytes);
    load_fifo(nbytes, nbytes, at);
    capture(at, len);
    build_exp(nbytes, 1'b1);
    chk(ncap == at + 32, "R7", $sformatf("length after collision at %0d", at), ncap, at + 32);
    cmp_bits("R7", 0, at);
    cmp_jam(at);
    chk(e_done && e_retry && e_bo && e_col && !e_ok && !e_unf, "R8", "collision outcome",
        int'({e_done, e_retry, e_bo, e_col, e_ok, e_unf}), 6'b111100);
    chk(!e_done_next, "R8", "pulses one cycle", int'(e_done_next), 0);
  endtask

  task automatic t_underflow();
    load_fifo(4, 2, 5);
    capture(0, 0);
    build_exp(4, 1'b0);
    chk(ncap == 64 + 16, "R9", "bits before starvation", ncap, 80);
    cmp_bits("R9", 0, 80);
    chk(e_done && e_retry && !e_bo && e_unf && !e_ok && !e_col, "R9", "underflow outcome",
        int'({e_done, e_retry, e_bo, e_unf, e_ok, e_col}), 6'b110100);
  endtask

  task automatic t_idle_collision();
    int bad = 0;
    load_fifo(0, 0, 0);
    collision = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (tx_en || done || retry_req || backoff_start || fifo_ready) bad++;
    end
    collision = 1'b0;
    chk(bad == 0, "R7", "activity from idle collision", bad, 0);
    chk(status_underflow && !status_collision, "R10", "status held while idle",
        int'({status_underflow, status_collision}), 2);
  endtask

  bit finished = 1'b0;

  initial begin
    rst_n = 1'b0; carrier_sense = 1'b0; collision = 1'b0; backoff_busy = 1'b0;
    no_crc = 1'b0; f_clear = 1'b1; flen = 0; favail = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_defer_and_frame();
    t_backoff_hold();
    t_no_crc();
    t_collision(10, 1, 3);
    t_collision(64 + 24 + 5, 1, 3);
    t_collision(70, 20, 4);
    t_underflow();
    t_idle_collision();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule